// File: doc/BRIEF.md
# PCIe Configuration Window Base Decoder

This block holds a 64-bit host-bridge register that places a memory-mapped PCIe configuration window in the physical address space. Software programs it through a byte-enabled configuration write port, one dword per write, at a fixed register offset. The register carries an enable bit, a two-bit length code and a set of base-address bits. Any write that touches either dword of the register makes the block recompute the active mapping: the enable, the base address and the window size.

The length code sets the window size and also decides how many low base bits take part in the base: a 256 MB window honours only 256 MB-aligned base bits, a 128 MB window also honours bit 27, and a 64 MB window honours bits 27 and 26 as well. The fourth length code is reserved. A write that leaves the reserved code in the register keeps the previous mapping in force and pulses an error flag for one cycle.

A combinational hit output tells whether an incoming physical address falls inside the active window. Reset loads a fixed default value into the register and derives the mapping from it.

Top module: `ecam_window_decoder`

## Requirements
- R1: After reset the register reads 64'h0000_0000_B000_0000, the window is disabled, the base is 40'hB0_0000_0000 >> 8 i.e. 40'h00_B000_0000, the size is 256 MB (40'h00_1000_0000) and len_err is low.
- R2: A write with cfg_wr_valid high updates only the bytes whose cfg_wr_be bit is set; address 12'h060 selects register bits 31:0 and address 12'h064 selects bits 63:32 (cfg_wr_addr bits 1:0 are ignored); any other address, or a write with all byte enables clear, changes nothing.
- R3: Length code in register bits 2:1: 2'b00 gives a 256 MB window with base = register bits 38:28, 2'b01 gives 128 MB with base = bits 38:27, 2'b10 gives 64 MB with base = bits 38:26; all other base bits are zero.
- R4: Register bit 0 drives win_en for every write that carries a valid length code.
- R5: When a write leaves length code 2'b11 in the register, the register stores the written value but win_en, win_base and win_size keep their previous values, and len_err is high in the cycle after that write only.
- R6: The register and mapping change on the clock edge that accepts the write and are visible in the following cycle; a later write to either dword with a valid length code rebuilds the mapping from the full register, including after a reserved code.
- R7: hit is combinational and is high exactly when win_en is high and phys_addr with its low log2(win_size) bits cleared equals win_base.
- R8: Only bits 0, 2:1 and 38:26 are writable (mask 64'h0000_007F_FC00_0007); all other register bits read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_valid | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 12 | Configuration byte address of the write |
| cfg_wr_be | input | 4 | Byte enables for the dword |
| cfg_wr_data | input | 32 | Write data dword |
| phys_addr | input | 40 | Physical address to decode |
| reg_rd | output | 64 | Current register contents |
| win_en | output | 1 | Active window enable |
| win_base | output | 40 | Active window base address |
| win_size | output | 40 | Active window size in bytes |
| len_err | output | 1 | One-cycle flag for a reserved length code |
| hit | output | 1 | phys_addr falls inside the active window |

## Verification
The hardest state to reach is a register that holds a reserved length code while the mapping reflects an older, different value, followed by a recovery write to the other dword. The stimulus table first builds a 64 MB mapping with a non-zero upper base, then writes the reserved code, changes the upper dword while the code is still reserved, and finally repairs the code with a single-byte write, so each step checks that the held mapping survives and that the repair rebuilds it from both dwords. The hit comparator is then probed at the first and last byte of the window, one byte below it, and with the top address bit set.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    LEN_256M = 2'b00,
    LEN_128M = 2'b01,
    LEN_64M  = 2'b10,
    LEN_RSVD = 2'b11
  } len_code_e;

  // Field positions inside the 64-bit window register
  localparam int EN_BIT   = 0;
  localparam int LEN_LSB  = 1;
  localparam int B64_BIT  = 26;
  localparam int B128_BIT = 27;
  localparam int B256_LSB = 28;
  localparam int B256_MSB = 38;

  localparam logic [63:0] WR_MASK = 64'h0000_007F_FC00_0007;

endpackage

// File: rtl/cfgwin_rst_sync.sv
module cfgwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile #(
  parameter int          CFG_AW     = 12,
  parameter logic [11:0] REG_OFFSET = 12'h060,
  parameter logic [63:0] RESET_VAL  = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              wr_valid,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  output logic              wr_hit,
  output logic [63:0]       reg_d,
  output logic [63:0]       reg_q
);
  import cfgwin_pkg::*;

  localparam logic [CFG_AW-1:0] OFS = CFG_AW'(REG_OFFSET);

  logic        sel_hi;
  logic [63:0] byte_bits;
  logic [63:0] data64;

  always_comb begin
    sel_hi = wr_addr[2];
    wr_hit = wr_valid && (wr_addr[CFG_AW-1:3] == OFS[CFG_AW-1:3]) && (wr_be != 4'b0000);
    data64 = sel_hi ? {wr_data, 32'h0} : {32'h0, wr_data};
    byte_bits = '0;
    for (int b = 0; b < 4; b++) begin
      if (wr_be[b]) begin
        if (sel_hi) byte_bits[32+8*b +: 8] = 8'hFF;
        else        byte_bits[8*b +: 8]    = 8'hFF;
      end
    end
    reg_d = (reg_q & ~byte_bits) | (data64 & byte_bits & WR_MASK);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    reg_q <= RESET_VAL & WR_MASK;
    else if (wr_hit) reg_q <= reg_d;
  end
endmodule

// File: rtl/cfgwin_map.sv
module cfgwin_map #(
  parameter int          ADDR_W    = 40,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              upd,
  input  logic [63:0]       reg_d,
  output logic              win_en,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_size,
  output logic              len_err
);
  import cfgwin_pkg::*;

  localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] M256  = ((ONE << (B256_MSB + 1)) - ONE) & ~((ONE << B256_LSB) - ONE);
  localparam logic [ADDR_W-1:0] M128  = M256 | (ONE << B128_BIT);
  localparam logic [ADDR_W-1:0] M64   = M128 | (ONE << B64_BIT);
  localparam logic [ADDR_W-1:0] S256  = ONE << B256_LSB;
  localparam logic [ADDR_W-1:0] S128  = ONE << B128_BIT;
  localparam logic [ADDR_W-1:0] S64   = ONE << B64_BIT;

  function automatic logic [ADDR_W-1:0] base_of(input logic [63:0] v);
    logic [ADDR_W-1:0] a;
    a = v[ADDR_W-1:0];
    case (len_code_e'(v[LEN_LSB +: 2]))
      LEN_128M: return a & M128;
      LEN_64M:  return a & M64;
      default:  return a & M256;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] size_of(input logic [63:0] v);
    case (len_code_e'(v[LEN_LSB +: 2]))
      LEN_128M: return S128;
      LEN_64M:  return S64;
      default:  return S256;
    endcase
  endfunction

  localparam logic [63:0]       RV       = RESET_VAL & WR_MASK;
  localparam logic              RST_EN   = RV[EN_BIT];
  localparam logic [ADDR_W-1:0] RST_BASE = base_of(RV);
  localparam logic [ADDR_W-1:0] RST_SIZE = size_of(RV);

  logic              rsvd;
  logic              load;
  logic              en_d, err_d;
  logic [ADDR_W-1:0] base_d, size_d;

  always_comb begin
    rsvd   = (len_code_e'(reg_d[LEN_LSB +: 2]) == LEN_RSVD);
    load   = upd && !rsvd;
    err_d  = upd && rsvd;
    en_d   = reg_d[EN_BIT];
    base_d = base_of(reg_d);
    size_d = size_of(reg_d);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      win_en   <= RST_EN;
      win_base <= RST_BASE;
      win_size <= RST_SIZE;
    end else if (load) begin
      win_en   <= en_d;
      win_base <= base_d;
      win_size <= size_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) len_err <= 1'b0;
    else          len_err <= err_d;
  end
endmodule

// File: rtl/cfgwin_hit.sv
module cfgwin_hit #(
  parameter int ADDR_W = 40
) (
  input  logic              win_en,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_size,
  input  logic [ADDR_W-1:0] phys_addr,
  output logic              hit
);
  logic [ADDR_W-1:0] keep;

  always_comb begin
    keep = ~(win_size - ADDR_W'(1));
    hit  = win_en && ((phys_addr & keep) == win_base);
  end
endmodule

// File: rtl/ecam_window_decoder.sv
module ecam_window_decoder #(
  parameter int          ADDR_W     = 40,
  parameter int          CFG_AW     = 12,
  parameter logic [11:0] REG_OFFSET = 12'h060,
  parameter logic [63:0] RESET_VAL  = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_valid,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [3:0]        cfg_wr_be,
  input  logic [31:0]       cfg_wr_data,
  input  logic [ADDR_W-1:0] phys_addr,
  output logic [63:0]       reg_rd,
  output logic              win_en,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_size,
  output logic              len_err,
  output logic              hit
);
  logic        rst_q_n;
  logic        wr_hit;
  logic [63:0] reg_d;

  cfgwin_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cfgwin_regfile #(
    .CFG_AW     (CFG_AW),
    .REG_OFFSET (REG_OFFSET),
    .RESET_VAL  (RESET_VAL)
  ) u_reg (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .wr_valid (cfg_wr_valid),
    .wr_addr  (cfg_wr_addr),
    .wr_be    (cfg_wr_be),
    .wr_data  (cfg_wr_data),
    .wr_hit   (wr_hit),
    .reg_d    (reg_d),
    .reg_q    (reg_rd)
  );

  cfgwin_map #(
    .ADDR_W    (ADDR_W),
    .RESET_VAL (RESET_VAL)
  ) u_map (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .upd      (wr_hit),
    .reg_d    (reg_d),
    .win_en   (win_en),
    .win_base (win_base),
    .win_size (win_size),
    .len_err  (len_err)
  );

  cfgwin_hit #(
    .ADDR_W (ADDR_W)
  ) u_hit (
    .win_en    (win_en),
    .win_base  (win_base),
    .win_size  (win_size),
    .phys_addr (phys_addr),
    .hit       (hit)
  );
endmodule

// File: rtl/cfgwin_checks.sv
module cfgwin_checks #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              wr_hit,
  input logic [63:0]       reg_rd,
  input logic              win_en,
  input logic [ADDR_W-1:0] win_base,
  input logic [ADDR_W-1:0] win_size,
  input logic              len_err,
  input logic              hit
);
  import cfgwin_pkg::*;

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  a_r5_rsvd_keeps_map: assert property (@(posedge clk) disable iff (!rst_q_n)
    len_err |-> ($stable(win_en) && $stable(win_base) && $stable(win_size)));

  a_r5_err_needs_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_hit |=> !len_err);

  a_r3_size_legal: assert property (@(posedge clk) disable iff (!rst_q_n)
    (win_size == (ONE << B256_LSB)) || (win_size == (ONE << B128_BIT)) || (win_size == (ONE << B64_BIT)));

  a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((win_base & (win_size - ONE)) == '0) && ((win_base >> (B256_MSB + 1)) == '0));

  a_r8_ro_bits_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_rd & ~WR_MASK) == 64'h0);

  a_r2_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_hit |=> $stable(reg_rd));

  a_r6_map_moves_on_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_hit |=> ($stable(win_en) && $stable(win_base) && $stable(win_size)));

  a_r7_hit_needs_en: assert property (@(posedge clk) disable iff (!rst_q_n)
    hit |-> win_en);
endmodule

bind ecam_window_decoder cfgwin_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .wr_hit   (wr_hit),
  .reg_rd   (reg_rd),
  .win_en   (win_en),
  .win_base (win_base),
  .win_size (win_size),
  .len_err  (len_err),
  .hit      (hit)
);

// File: tb/sim_ecam_window_decoder.sv
module sim_ecam_window_decoder;
  localparam int AW = 40;
  localparam logic [AW-1:0] S256 = 40'h00_1000_0000;
  localparam logic [AW-1:0] S128 = 40'h00_0800_0000;
  localparam logic [AW-1:0] S64  = 40'h00_0400_0000;

  typedef struct packed {
    logic [11:0]   a;
    logic [3:0]    be;
    logic [31:0]   d;
    logic [63:0]   xreg;
    logic          en;
    logic [AW-1:0] base;
    logic [AW-1:0] size;
    logic          err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{12'h060, 4'hF, 32'hE000_0001, 64'h0000_0000_E000_0001, 1'b1, 40'h00_E000_0000, S256, 1'b0},
    '{12'h064, 4'h1, 32'h0000_0012, 64'h0000_0012_E000_0001, 1'b1, 40'h12_E000_0000, S256, 1'b0},
    '{12'h060, 4'h1, 32'h0000_0003, 64'h0000_0012_E000_0003, 1'b1, 40'h12_E000_0000, S128, 1'b0},
    '{12'h060, 4'h8, 32'h0C00_0000, 64'h0000_0012_0C00_0003, 1'b1, 40'h12_0800_0000, S128, 1'b0},
    '{12'h060, 4'h1, 32'h0000_0005, 64'h0000_0012_0C00_0005, 1'b1, 40'h12_0C00_0000, S64,  1'b0},
    '{12'h060, 4'h1, 32'h0000_0007, 64'h0000_0012_0C00_0007, 1'b1, 40'h12_0C00_0000, S64,  1'b1},
    '{12'h064, 4'h1, 32'h0000_0001, 64'h0000_0001_0C00_0007, 1'b1, 40'h12_0C00_0000, S64,  1'b1},
    '{12'h060, 4'h1, 32'h0000_0000, 64'h0000_0001_0C00_0000, 1'b0, 40'h01_0000_0000, S256, 1'b0},
    '{12'h060, 4'hF, 32'hFFFF_FFFF, 64'h0000_0001_FC00_0007, 1'b0, 40'h01_0000_0000, S256, 1'b1},
    '{12'h064, 4'hF, 32'hFFFF_FFFF, 64'h0000_007F_FC00_0007, 1'b0, 40'h01_0000_0000, S256, 1'b1},
    '{12'h060, 4'h1, 32'h0000_0002, 64'h0000_007F_FC00_0002, 1'b0, 40'h7F_F800_0000, S128, 1'b0},
    '{12'h068, 4'hF, 32'h0000_0000, 64'h0000_007F_FC00_0002, 1'b0, 40'h7F_F800_0000, S128, 1'b0},
    '{12'h060, 4'h0, 32'h0000_0000, 64'h0000_007F_FC00_0002, 1'b0, 40'h7F_F800_0000, S128, 1'b0},
    '{12'h05C, 4'hF, 32'h0000_0000, 64'h0000_007F_FC00_0002, 1'b0, 40'h7F_F800_0000, S128, 1'b0},
    '{12'h060, 4'h2, 32'h0000_FF00, 64'h0000_007F_FC00_0002, 1'b0, 40'h7F_F800_0000, S128, 1'b0},
    '{12'h060, 4'h1, 32'h0000_00FD, 64'h0000_007F_FC00_0005, 1'b1, 40'h7F_FC00_0000, S64,  1'b0}
  };

  logic          clk;
  logic          rst_n;
  logic          cfg_wr_valid;
  logic [11:0]   cfg_wr_addr;
  logic [3:0]    cfg_wr_be;
  logic [31:0]   cfg_wr_data;
  logic [AW-1:0] phys_addr;
  logic [63:0]   reg_rd;
  logic          win_en;
  logic [AW-1:0] win_base;
  logic [AW-1:0] win_size;
  logic          len_err;
  logic          hit;

  int n_chk;
  int n_bad;
  bit done;

  ecam_window_decoder u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_valid (cfg_wr_valid),
    .cfg_wr_addr  (cfg_wr_addr),
    .cfg_wr_be    (cfg_wr_be),
    .cfg_wr_data  (cfg_wr_data),
    .phys_addr    (phys_addr),
    .reg_rd       (reg_rd),
    .win_en       (win_en),
    .win_base     (win_base),
    .win_size     (win_size),
    .len_err      (len_err),
    .hit          (hit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_valid = 1'b1;
    cfg_wr_addr  = a;
    cfg_wr_be    = be;
    cfg_wr_data  = d;
    @(negedge clk);
    cfg_wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_defaults(input string tag);
    check({tag, " R1 reg"},  reg_rd, 64'h0000_0000_B000_0000);
    check({tag, " R1 en"},   64'(win_en), 64'd0);
    check({tag, " R1 base"}, 64'(win_base), 64'h00_B000_0000);
    check({tag, " R1 size"}, 64'(win_size), 64'(S256));
    check({tag, " R1 err"},  64'(len_err), 64'd0);
  endtask

  task automatic probe(input string tag, input logic [AW-1:0] a, input logic exp);
    phys_addr = a;
    #1;
    check(tag, 64'(hit), 64'(exp));
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    cfg_wr_valid = 1'b0;
    cfg_wr_addr  = '0;
    cfg_wr_be    = '0;
    cfg_wr_data  = '0;
    phys_addr    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check_defaults("reset");
    probe("R7 disabled default window", 40'h00_B000_0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].a, VEC[i].be, VEC[i].d);
      check($sformatf("R2/R8 vec%0d reg", i), reg_rd, VEC[i].xreg);
      check($sformatf("R4 vec%0d en", i), 64'(win_en), 64'(VEC[i].en));
      check($sformatf("R3/R6 vec%0d base", i), 64'(win_base), 64'(VEC[i].base));
      check($sformatf("R3 vec%0d size", i), 64'(win_size), 64'(VEC[i].size));
      check($sformatf("R5 vec%0d err", i), 64'(len_err), 64'(VEC[i].err));
    end

    // Window now enabled, 64 MB at 40'h7F_FC00_0000
    probe("R7 first byte", 40'h7F_FC00_0000, 1'b1);
    probe("R7 last byte",  40'h7F_FFFF_FFFF, 1'b1);
    probe("R7 below base", 40'h7F_FBFF_FFFF, 1'b0);
    probe("R7 top bit set", 40'hFF_FC00_0000, 1'b0);

    // Reserved code: error flag lasts one cycle only
    do_write(12'h060, 4'h1, 32'h0000_0007);
    check("R5 err raised", 64'(len_err), 64'd1);
    check("R5 base held", 64'(win_base), 64'h7F_FC00_0000);
    probe("R5 hit with held map", 40'h7F_FC00_0010, 1'b1);
    @(negedge clk);
    check("R5 err one cycle", 64'(len_err), 64'd0);

    // Valid code with enable clear disables decode
    do_write(12'h060, 4'h1, 32'h0000_0004);
    check("R4 en cleared", 64'(win_en), 64'd0);
    probe("R7 no hit when disabled", 40'h7F_FC00_0000, 1'b0);

    // Reset mid-run returns to defaults
    do_reset();
    check_defaults("rerun");

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R6 actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule